// File: doc/BRIEF.md
# Pushbutton Master Volume Controller

This block turns three active-low pushbuttons into a master gain setting and a mute flag for a downstream gain stage. Each button pin is synchronised and debounced. The up and down buttons move a step index through 25 settings, in 2 dB steps from -36 dB to +12 dB. A button that stays held keeps stepping after an initial delay.

A single enable input switches the whole function on. Two format bits choose how mute is produced:

- A mute button that toggles the flag on each press.
- A mute button that mutes only while it is held.
- No mute button at all, with up and down pressed together muting the output.

The outputs are the step index and the mute flag. The gain stage applies both.

All timing is given in clock cycles through parameters. The defaults suit a 50 MHz clock: 10 ms debounce, 500 ms repeat delay and 100 ms repeat period.

Top module: `mvol_ctrl`

## Requirements
- R1: After reset, vol_code is 18 (0 dB) and mute_on is 0. vol_code 0 means -36 dB, 24 means +12 dB, and each code step is 2 dB.
- R2: Each debounced press of up_n (low) raises vol_code by one. Each debounced press of down_n (low) lowers it by one. A press held for less than RPT_DELAY cycles gives exactly one step.
- R3: vol_code never rises above 24 and never falls below 0. Steps past either end leave it unchanged.
- R4: While up_n or down_n stays held, a further step follows RPT_DELAY cycles after the first step. After that, one step follows every RPT_PERIOD cycles until release.
- R5: All button pins are active low and pass through a two-stage synchroniser. A level that lasts fewer than DEB_CYCLES consecutive cycles has no effect.
- R6: While vc_en is 0, all three button pins are ignored, and vol_code and the toggle or chord mute state do not change.
- R7: When mute_fmt is 2'b00, each debounced press of mute_n inverts mute_on.
- R8: When mute_fmt is 2'b01, mute_on is 1 exactly while the debounced mute_n is held, and steps do not affect it.
- R9: When mute_fmt is 2'b10 or 2'b11, mute_n is ignored. Holding up_n and down_n together sets mute_on and suppresses stepping, except that the button pressed first still steps once.
- R10: When mute_fmt is not 2'b01, any single up or down step clears mute_on.
- R11: When mute_fmt is 2'b00 or 2'b01, an up step and a down step in the same cycle leave vol_code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vc_en | input | 1 | Turns the button function on |
| mute_fmt | input | 2 | Mute format: 00 toggle, 01 momentary, 1x up+down chord |
| up_n | input | 1 | Volume up button, active low |
| down_n | input | 1 | Volume down button, active low |
| mute_n | input | 1 | Mute button, active low |
| vol_code | output | VW (5) | Step index, 0 = -36 dB up to 24 = +12 dB |
| mute_on | output | 1 | Mute flag for the gain stage |

## Verification
The bench drives both saturation ends with long holds. A design that wraps would produce 0 after 24, or 24 after 0.

It uses a hold long enough for exactly three repeats. A repeat counter that is off by one period, or one that restarts on each step, gives a different final code.

A two-cycle glitch checks the debounce. A filter that is too short would step on it.

Up and down are pressed with a small offset in chord mode. A design that keeps stepping during the chord, or that honours the mute pin in that mode, ends on the wrong code or the wrong mute state.

In toggle and momentary modes, simultaneous presses must cancel each other. Pressing with the enable off must change nothing.

// File: rtl/mvol_pkg.sv
package mvol_pkg;

   typedef enum logic [1:0] {
      MF_TOGGLE  = 2'b00,
      MF_HOLD    = 2'b01,
      MF_CHORD   = 2'b10,
      MF_CHORD_B = 2'b11
   } mute_fmt_e;

   localparam int BTN_UP   = 0;
   localparam int BTN_DN   = 1;
   localparam int BTN_MUTE = 2;
   localparam int NUM_BTN  = 3;

endpackage

// File: rtl/mvol_btn_filter.sv
module mvol_btn_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic pressed
);
   localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   level_n;
   logic                   clean_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
   end

   assign level_n = sync_q[SYNC_STAGES-1];

   if (DEB_CYCLES <= 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) clean_n <= 1'b1;
         else        clean_n <= level_n;
      end
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            clean_n <= 1'b1;
            cnt_q   <= '0;
         end else if (level_n == clean_n) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
            clean_n <= level_n;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign pressed = ~clean_n;
endmodule

// File: rtl/mvol_step_gen.sv
module mvol_step_gen #(
   parameter bit AUTO_REPEAT = 1'b1,
   parameter int RPT_DELAY   = 64,
   parameter int RPT_PERIOD  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic held,
   input  logic hold_off,
   output logic step
);
   localparam int RMAX = (RPT_DELAY > RPT_PERIOD) ? RPT_DELAY : RPT_PERIOD;
   localparam int CW   = $clog2(RMAX + 1);

   logic held_q;
   logic rise;

   assign rise = held & ~held_q;

   if (AUTO_REPEAT) begin : g_repeat
      logic          armed_q;
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held_q  <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
            step    <= 1'b0;
         end else begin
            held_q <= held;
            step   <= 1'b0;
            if (!held || hold_off) begin
               armed_q <= 1'b0;
            end else if (rise) begin
               step    <= 1'b1;
               armed_q <= 1'b1;
               cnt_q   <= CW'(RPT_DELAY - 1);
            end else if (armed_q) begin
               if (cnt_q == '0) begin
                  step  <= 1'b1;
                  cnt_q <= CW'(RPT_PERIOD - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
         end
      end
   end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held_q <= 1'b0;
            step   <= 1'b0;
         end else begin
            held_q <= held;
            step   <= rise & ~hold_off;
         end
      end
   end
endmodule

// File: rtl/mvol_core.sv
module mvol_core
   import mvol_pkg::*;
#(
   parameter int VOL_STEPS = 25,
   parameter int VOL_RESET = 18,
   parameter int VW        = $clog2(VOL_STEPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          up_step,
   input  logic          dn_step,
   input  logic          mute_held,
   input  logic          chord_held,
   input  mute_fmt_e     fmt,
   output logic [VW-1:0] vol_code,
   output logic          mute_on
);
   localparam logic [VW-1:0] VMAX = VW'(VOL_STEPS - 1);

   logic mute_prev_q, chord_prev_q;
   logic mute_rise, chord_rise, one_step;

   assign mute_rise  = mute_held & ~mute_prev_q;
   assign chord_rise = chord_held & ~chord_prev_q;
   assign one_step   = up_step ^ dn_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vol_code <= VW'(VOL_RESET);
      end else if (up_step && !dn_step && vol_code != VMAX) begin
         vol_code <= vol_code + 1'b1;
      end else if (dn_step && !up_step && vol_code != '0) begin
         vol_code <= vol_code - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mute_prev_q  <= 1'b0;
         chord_prev_q <= 1'b0;
         mute_on      <= 1'b0;
      end else begin
         mute_prev_q  <= mute_held;
         chord_prev_q <= chord_held;
         unique case (fmt)
            MF_HOLD:   mute_on <= mute_held;
            MF_TOGGLE: begin
               if (one_step)       mute_on <= 1'b0;
               else if (mute_rise) mute_on <= ~mute_on;
            end
            default: begin
               if (one_step)        mute_on <= 1'b0;
               else if (chord_rise) mute_on <= 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/mvol_ctrl.sv
module mvol_ctrl
   import mvol_pkg::*;
#(
   parameter int VOL_STEPS   = 25,
   parameter int VOL_RESET   = 18,
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 500_000,
   parameter bit AUTO_REPEAT = 1'b1,
   parameter int RPT_DELAY   = 25_000_000,
   parameter int RPT_PERIOD  = 5_000_000,
   parameter int VW          = $clog2(VOL_STEPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vc_en,
   input  logic [1:0]    mute_fmt,
   input  logic          up_n,
   input  logic          down_n,
   input  logic          mute_n,
   output logic [VW-1:0] vol_code,
   output logic          mute_on
);
   if (VOL_STEPS < 2)                         $error("VOL_STEPS must be at least 2");
   if (VOL_RESET < 0 || VOL_RESET >= VOL_STEPS) $error("VOL_RESET out of range");
   if (SYNC_STAGES < 2)                       $error("SYNC_STAGES must be at least 2");
   if (RPT_DELAY < 1 || RPT_PERIOD < 1)       $error("repeat timing must be positive");

   logic [NUM_BTN-1:0] pins_n, pressed, act;
   logic               chord_held, up_step, dn_step;
   mute_fmt_e          fmt;

   assign pins_n = {mute_n, down_n, up_n};
   assign fmt    = mute_fmt_e'(mute_fmt);

   for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
      mvol_btn_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) u_flt (
         .clk(clk), .rst_n(rst_n), .pin_n(pins_n[b]), .pressed(pressed[b]));
   end

   assign act        = pressed & {NUM_BTN{vc_en}};
   assign chord_held = mute_fmt[1] & act[BTN_UP] & act[BTN_DN];

   mvol_step_gen #(.AUTO_REPEAT(AUTO_REPEAT), .RPT_DELAY(RPT_DELAY), .RPT_PERIOD(RPT_PERIOD)) u_up (
      .clk(clk), .rst_n(rst_n), .held(act[BTN_UP]), .hold_off(chord_held), .step(up_step));

   mvol_step_gen #(.AUTO_REPEAT(AUTO_REPEAT), .RPT_DELAY(RPT_DELAY), .RPT_PERIOD(RPT_PERIOD)) u_dn (
      .clk(clk), .rst_n(rst_n), .held(act[BTN_DN]), .hold_off(chord_held), .step(dn_step));

   mvol_core #(.VOL_STEPS(VOL_STEPS), .VOL_RESET(VOL_RESET), .VW(VW)) u_core (
      .clk(clk), .rst_n(rst_n), .up_step(up_step), .dn_step(dn_step),
      .mute_held(act[BTN_MUTE]), .chord_held(chord_held), .fmt(fmt),
      .vol_code(vol_code), .mute_on(mute_on));
endmodule

// File: rtl/mvol_ctrl_chk.sv
module mvol_ctrl_chk #(
   parameter int VOL_STEPS = 25,
   parameter int VOL_RESET = 18,
   parameter int VW        = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          vc_en,
   input logic [1:0]    mute_fmt,
   input logic          up_step,
   input logic          dn_step,
   input logic          mute_held,
   input logic [VW-1:0] vol_code,
   input logic          mute_on
);
   logic [VW:0] vol_x;
   assign vol_x = {1'b0, vol_code};

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (vol_code == VW'(VOL_RESET) && !mute_on));

   // R3
   vol_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vol_x <= (VW+1)'(VOL_STEPS - 1));

   // R2
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (vol_x == $past(vol_x) || vol_x == $past(vol_x) + 1'b1
                || vol_x + 1'b1 == $past(vol_x)));

   // R6
   disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!vc_en && $past(!vc_en)) |=> $stable(vol_code));

   // R10
   step_clears_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((up_step ^ dn_step) && mute_fmt != 2'b01) |=> !mute_on);

   // R8
   hold_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_fmt == 2'b01) |=> (mute_on == $past(mute_held)));
endmodule

bind mvol_ctrl mvol_ctrl_chk #(.VOL_STEPS(VOL_STEPS), .VOL_RESET(VOL_RESET), .VW(VW)) u_chk (
   .clk(clk), .rst_n(rst_n), .vc_en(vc_en), .mute_fmt(mute_fmt),
   .up_step(up_step), .dn_step(dn_step), .mute_held(act[BTN_MUTE]),
   .vol_code(vol_code), .mute_on(mute_on));

// File: tb/tb_mvol_ctrl.sv
module tb_mvol_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int DEB        = 4;
   localparam int DLY        = 40;
   localparam int PER        = 10;
   localparam int SETTLE     = DEB + 8;
   localparam int SHORT      = 12;

   typedef struct {
      int    vol;
      bit    mute;
      string req;
   } exp_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vc_en = 1'b0;
   logic [1:0] mute_fmt = 2'b00;
   logic       up_n = 1'b1, down_n = 1'b1, mute_n = 1'b1;
   logic [4:0] vol_code;
   logic       mute_on;

   exp_item_t exp_q[$];
   event      chk_ev;
   int        n_chk = 0, n_fail = 0;
   bit        done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mvol_ctrl #(.DEB_CYCLES(DEB), .RPT_DELAY(DLY), .RPT_PERIOD(PER)) dut (
      .clk(clk), .rst_n(rst_n), .vc_en(vc_en), .mute_fmt(mute_fmt),
      .up_n(up_n), .down_n(down_n), .mute_n(mute_n),
      .vol_code(vol_code), .mute_on(mute_on));

   // monitor: pops expected items and compares with the outputs
   initial begin
      forever begin
         @(chk_ev);
         while (exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            n_chk++;
            if (int'(vol_code) != it.vol || mute_on != it.mute) begin
               n_fail++;
               $display("FAIL %s: vol=%0d mute=%0b expected vol=%0d mute=%0b",
                        it.req, vol_code, mute_on, it.vol, it.mute);
            end
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_now(int v, bit m, string req);
      exp_item_t it;
      it.vol = v; it.mute = m; it.req = req;
      exp_q.push_back(it);
      -> chk_ev;
   endtask

   task automatic press(bit u, bit d, bit m, int hold);
      up_n = ~u; down_n = ~d; mute_n = ~m;
      tick(hold);
      up_n = 1'b1; down_n = 1'b1; mute_n = 1'b1;
      tick(SETTLE);
   endtask

   task automatic finish_run();
      tick(2);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      expect_now(18, 0, "R1 reset state");

      // R6: disabled, nothing moves
      press(1, 0, 0, SHORT);
      expect_now(18, 0, "R6 up ignored when disabled");
      press(0, 0, 1, SHORT);
      expect_now(18, 0, "R6 mute ignored when disabled");

      vc_en = 1'b1;
      tick(2);
      press(1, 0, 0, SHORT);
      expect_now(19, 0, "R2 single up press");
      press(0, 1, 0, SHORT);
      press(0, 1, 0, SHORT);
      expect_now(17, 0, "R2 two down presses");

      // R5: short glitch filtered
      press(1, 0, 0, 2);
      expect_now(17, 0, "R5 glitch shorter than debounce");

      // R7 toggle
      press(0, 0, 1, SHORT);
      expect_now(17, 1, "R7 toggle on");
      press(0, 0, 1, SHORT);
      expect_now(17, 0, "R7 toggle off");
      press(0, 0, 1, SHORT);
      expect_now(17, 1, "R7 toggle on again");
      press(1, 0, 0, SHORT);
      expect_now(18, 0, "R10 up step clears mute");

      // R4 auto-repeat: steps at 0, DLY, DLY+PER, DLY+2*PER
      press(1, 0, 0, DLY + 2*PER + PER/2);
      expect_now(22, 0, "R4 hold gives three repeats");

      // R3 saturation
      press(1, 0, 0, DLY + 20*PER);
      expect_now(24, 0, "R3 saturate at top");
      press(0, 1, 0, DLY + 30*PER);
      expect_now(0, 0, "R3 saturate at bottom");
      press(1, 0, 0, SHORT);
      expect_now(1, 0, "R2 step up from bottom");

      // R8 momentary
      mute_fmt = 2'b01;
      mute_n = 1'b0;
      tick(SETTLE);
      expect_now(1, 1, "R8 mute while held");
      mute_n = 1'b1;
      tick(SETTLE);
      expect_now(1, 0, "R8 mute released");

      // R9 chord
      mute_fmt = 2'b10;
      up_n = 1'b0;
      tick(3);
      down_n = 1'b0;
      tick(20);
      up_n = 1'b1; down_n = 1'b1;
      tick(SETTLE);
      expect_now(2, 1, "R9 chord mutes, first button steps once");
      press(0, 0, 1, SHORT);
      expect_now(2, 1, "R9 mute pin ignored in chord mode");
      press(0, 1, 0, SHORT);
      expect_now(1, 0, "R10 down step clears chord mute");

      // R11 simultaneous presses cancel
      mute_fmt = 2'b00;
      press(1, 1, 0, SHORT);
      expect_now(1, 0, "R11 simultaneous up and down cancel");

      // R6: disabled again, toggle state kept
      press(0, 0, 1, SHORT);
      vc_en = 1'b0;
      tick(2);
      press(0, 1, 0, SHORT);
      press(0, 0, 1, SHORT);
      expect_now(1, 1, "R6 state kept while disabled");

      done = 1;
      finish_run();
   end
endmodule